// File: doc/BRIEF.md
# Cache Error Trap Dispatcher

This block decides what happens when the cache or the system bus reports an ECC or bus fault. Each error event arrives with a class, the operation that caused it, and a flag that says whether the fault came from a local cache read or from the bus. Three enable bits in a software-written control register decide whether a trap is raised. When a trap is raised, the block picks one of four kinds: a fast ECC trap, an instruction-access trap, a data-access trap or a disrupting ECC trap. Every event is also recorded in a sticky status register, whether or not its trap is enabled. Software clears status bits by writing ones to them.

The same control register holds override values for the ECC check bits written to the data array and to the memory tag. When a force bit is set, its value replaces the check bits that the generator produced on the write path. Several event ports may fire in the same cycle. A fixed precedence picks the single trap pulse for that cycle, and the status bits of every event are set.

Top module: `eccTrapDispatch`

## Requirements
- R1: After reset (async, active-low `rstN`), the control register reads 0, the status register reads 0 and `trapValid` is low.
- R2: A control write stores only the defined fields: bit 0 correctable enable, bit 1 uncorrectable/system enable, bit 3 fast enable, bits 12:4 forced data check value, bit 13 force-data, bits 17:14 forced tag check value, bit 18 force-tag. All other bits read 0 (an all-ones write reads back 0x0007FFFB). The register holds its value when no write occurs.
- R3: An event with `evtFromCache`=1, operation load (0), instruction fetch (1) or atomic (2), and class software-correctable (1) or uncorrectable data (2) is a fast event. With the fast enable set, it raises trap type 0 one cycle later. It sets status bit 0 for class 1 and status bit 1 for class 2.
- R4: A cache event on store merge (3), writeback (4) or copyout (5) never raises trap type 0. Classes 2 to 5 from such an event follow R5, and classes 0 and 1 follow R7.
- R5: With the uncorrectable enable set, any other event of class uncorrectable data (2), uncorrectable tag (3), bus timeout (4) or bus error (5) raises a trap chosen by operation. Instruction fetch gives type 1 (instruction access). Load or atomic gives type 2 (data access). Store merge, writeback or copyout gives type 3 (disrupting). The event sets status bit (class+1).
- R6: For such an event on an interrupt-vector fetch (operation 6), `vecTrapSel` chooses the trap type. A value of 1 gives type 1, 2 gives type 2, and 0 or 3 gives type 3.
- R7: With the correctable enable set, a hardware-corrected event (class 0), or a class 1 event that is not a fast event, raises trap type 3 and sets status bit 2.
- R8: When the enable that governs an event is clear, no trap is raised, but its status bit is still set on the next cycle.
- R9: Status bits are sticky. A `staClr` pulse clears the bits set in `staClrMask`. If a bit is set by an event in the same cycle as its clear, the bit stays set.
- R10: When several events arrive in one cycle, exactly one trap pulse results. Its type is the lowest-numbered type requested (0 before 1 before 2 before 3). The status bits of all the events are set.
- R11: With force-data set, `wrDataCheck` equals the forced data value. Otherwise it equals `genDataCheck`. Force-tag does the same for `wrTagCheck` and `genTagCheck`. Both outputs follow the control register without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Control register write strobe |
| regWrData | input | 32 | Control register write data |
| regRdData | output | 32 | Control register contents |
| evtValid | input | 2 | Per-port event strobe |
| evtClass | input | 6 | Per-port error class, 3 bits each |
| evtOp | input | 6 | Per-port source operation, 3 bits each |
| evtFromCache | input | 2 | Per-port origin, 1 = local cache read, 0 = bus |
| vecTrapSel | input | 2 | Trap choice for interrupt-vector fetch errors |
| staClr | input | 1 | Write-one-to-clear strobe for status |
| staClrMask | input | 7 | Status bits to clear |
| staRdData | output | 7 | Sticky status register |
| trapValid | output | 1 | One-cycle trap pulse |
| trapType | output | 2 | Trap kind: 0 fast, 1 instr access, 2 data access, 3 disrupting |
| genDataCheck | input | 9 | Generated data check bits |
| genTagCheck | input | 4 | Generated tag check bits |
| wrDataCheck | output | 9 | Data check bits to write |
| wrTagCheck | output | 4 | Tag check bits to write |

## Verification
An event takes one clock edge to appear on `trapValid`/`trapType` and on the status bits. A control write or status clear takes one edge to show in the register readback. The check-bit override outputs are combinational from the registered control value, so they follow a write at the same edge. The bench drives inputs on the falling edge and advances a behavioural model just after the rising edge. It then compares every output against that model on the next falling edge, so each result is compared in the cycle it is due.

// File: rtl/errTrapPkg.sv
package errTrapPkg;
  localparam int CLS_W = 3;
  localparam int OP_W  = 3;
  localparam int STA_W = 7;

  typedef enum logic [CLS_W-1:0] {
    CLS_HWCOR   = 3'd0,
    CLS_SWCOR   = 3'd1,
    CLS_UEDATA  = 3'd2,
    CLS_UETAG   = 3'd3,
    CLS_TIMEOUT = 3'd4,
    CLS_BUSERR  = 3'd5
  } errClass_e;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD   = 3'd0,
    OP_IFETCH = 3'd1,
    OP_ATOMIC = 3'd2,
    OP_MERGE  = 3'd3,
    OP_WBACK  = 3'd4,
    OP_COPY   = 3'd5,
    OP_VECTOR = 3'd6
  } srcOp_e;

  typedef enum logic [1:0] {
    TRAP_FAST    = 2'd0,
    TRAP_INSTR   = 2'd1,
    TRAP_DATA    = 2'd2,
    TRAP_DISRUPT = 2'd3
  } trapKind_e;

  localparam int STA_FAST_COR = 0;
  localparam int STA_FAST_UNC = 1;
  localparam int STA_COR      = 2;

  typedef struct packed {
    logic [STA_W-1:0] staSet;
    logic             trapFire;
    trapKind_e        trapKind;
  } ctrlStrb_t;
endpackage

// File: rtl/errTrapCtrl.sv
module errTrapCtrl
  import errTrapPkg::*;
#(
  parameter int NUM_EVT = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_EVT-1:0]       evtValid,
  input  logic [NUM_EVT*CLS_W-1:0] evtClass,
  input  logic [NUM_EVT*OP_W-1:0]  evtOp,
  input  logic [NUM_EVT-1:0]       evtFromCache,
  input  logic [1:0]               vecTrapSel,
  input  logic                     ceEn,
  input  logic                     ncEn,
  input  logic                     fastEn,
  output ctrlStrb_t                strb
);
  logic [NUM_EVT-1:0] wFast, wInstr, wData, wDisr;
  logic [STA_W-1:0]   evSet [NUM_EVT];

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    errClass_e cls;
    srcOp_e    op;
    logic      readOp, fastHit, corHit, uncHit;
    trapKind_e uncKind;
    logic [STA_W-1:0] setV;

    assign cls     = errClass_e'(evtClass[CLS_W*i +: CLS_W]);
    assign op      = srcOp_e'(evtOp[OP_W*i +: OP_W]);
    assign readOp  = (op == OP_LOAD) || (op == OP_IFETCH) || (op == OP_ATOMIC);
    assign fastHit = evtValid[i] && evtFromCache[i] && readOp &&
                     ((cls == CLS_SWCOR) || (cls == CLS_UEDATA));
    assign corHit  = evtValid[i] && !fastHit && ((cls == CLS_HWCOR) || (cls == CLS_SWCOR));
    assign uncHit  = evtValid[i] && !fastHit &&
                     ((cls == CLS_UEDATA) || (cls == CLS_UETAG) ||
                      (cls == CLS_TIMEOUT) || (cls == CLS_BUSERR));

    always_comb begin
      unique case (op)
        OP_IFETCH:         uncKind = TRAP_INSTR;
        OP_LOAD, OP_ATOMIC: uncKind = TRAP_DATA;
        OP_VECTOR: begin
          if (vecTrapSel == 2'd1)      uncKind = TRAP_INSTR;
          else if (vecTrapSel == 2'd2) uncKind = TRAP_DATA;
          else                         uncKind = TRAP_DISRUPT;
        end
        default:           uncKind = TRAP_DISRUPT;
      endcase
    end

    always_comb begin
      setV = '0;
      if (fastHit) setV[(cls == CLS_SWCOR) ? STA_FAST_COR : STA_FAST_UNC] = 1'b1;
      if (corHit)  setV[STA_COR] = 1'b1;
      if (uncHit)  setV[int'(cls) + 1] = 1'b1;
    end

    assign evSet[i]  = setV;
    assign wFast[i]  = fastHit && fastEn;
    assign wInstr[i] = uncHit && ncEn && (uncKind == TRAP_INSTR);
    assign wData[i]  = uncHit && ncEn && (uncKind == TRAP_DATA);
    assign wDisr[i]  = (uncHit && ncEn && (uncKind == TRAP_DISRUPT)) || (corHit && ceEn);
  end

  always_comb begin
    strb.staSet = '0;
    for (int i = 0; i < NUM_EVT; i++) strb.staSet = strb.staSet | evSet[i];
    strb.trapFire = |{wFast, wInstr, wData, wDisr};
    if (|wFast)       strb.trapKind = TRAP_FAST;
    else if (|wInstr) strb.trapKind = TRAP_INSTR;
    else if (|wData)  strb.trapKind = TRAP_DATA;
    else              strb.trapKind = TRAP_DISRUPT;
  end

  // R3: a fast trap request needs the fast enable
  p_fast_gated_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.trapFire && strb.trapKind == TRAP_FAST) |-> fastEn);
  // R8: no enable, no trap request
  p_mask_no_trap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!ceEn && !ncEn && !fastEn) |-> !strb.trapFire);
endmodule

// File: rtl/errTrapDatapath.sv
module errTrapDatapath
  import errTrapPkg::*;
#(
  parameter int REG_W  = 32,
  parameter int DCHK_W = 9,
  parameter int TCHK_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              staClr,
  input  logic [STA_W-1:0]  staClrMask,
  output logic [STA_W-1:0]  staRdData,
  input  ctrlStrb_t         strb,
  output logic              trapValid,
  output logic [1:0]        trapType,
  input  logic [DCHK_W-1:0] genDataCheck,
  input  logic [TCHK_W-1:0] genTagCheck,
  output logic [DCHK_W-1:0] wrDataCheck,
  output logic [TCHK_W-1:0] wrTagCheck,
  output logic              ceEn,
  output logic              ncEn,
  output logic              fastEn
);
  localparam int CE_BIT  = 0;
  localparam int NC_BIT  = 1;
  localparam int FST_BIT = 3;
  localparam int FDV_LSB = 4;
  localparam int FD_BIT  = FDV_LSB + DCHK_W;
  localparam int FTV_LSB = FD_BIT + 1;
  localparam int FT_BIT  = FTV_LSB + TCHK_W;

  function automatic logic [REG_W-1:0] mkMask();
    logic [REG_W-1:0] m = '0;
    m[CE_BIT]  = 1'b1;
    m[NC_BIT]  = 1'b1;
    m[FST_BIT] = 1'b1;
    for (int b = FDV_LSB; b <= FT_BIT; b++) m[b] = 1'b1;
    return m;
  endfunction
  localparam logic [REG_W-1:0] WR_MASK = mkMask();

  logic [REG_W-1:0] enReg;
  logic [STA_W-1:0] staReg;
  logic [STA_W-1:0] clrVec;

  assign clrVec = staClr ? staClrMask : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg     <= '0;
      staReg    <= '0;
      trapValid <= 1'b0;
      trapType  <= 2'd0;
    end else begin
      if (regWr) enReg <= regWrData & WR_MASK;
      staReg    <= (staReg & ~clrVec) | strb.staSet;
      trapValid <= strb.trapFire;
      trapType  <= strb.trapFire ? strb.trapKind : 2'd0;
    end
  end

  assign regRdData   = enReg;
  assign staRdData   = staReg;
  assign ceEn        = enReg[CE_BIT];
  assign ncEn        = enReg[NC_BIT];
  assign fastEn      = enReg[FST_BIT];
  assign wrDataCheck = enReg[FD_BIT] ? enReg[FDV_LSB +: DCHK_W] : genDataCheck;
  assign wrTagCheck  = enReg[FT_BIT] ? enReg[FTV_LSB +: TCHK_W] : genTagCheck;

  // R8: every trap pulse leaves a logged status bit
  p_trap_logged_r8: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |-> (staReg != '0));
  // R9: a set bit survives unless a clear targeted it
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(staReg) & ~$past(clrVec)) & ~staReg) == '0));
  // R9: a set request always lands, even against a clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(strb.staSet) & ~staReg) == '0));
  // R2: the control register only changes on a write
  p_en_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !regWr |=> $stable(enReg));
endmodule

// File: rtl/eccTrapDispatch.sv
module eccTrapDispatch
  import errTrapPkg::*;
#(
  parameter int NUM_EVT = 2,
  parameter int REG_W   = 32,
  parameter int DCHK_W  = 9,
  parameter int TCHK_W  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     regWr,
  input  logic [REG_W-1:0]         regWrData,
  output logic [REG_W-1:0]         regRdData,
  input  logic [NUM_EVT-1:0]       evtValid,
  input  logic [NUM_EVT*CLS_W-1:0] evtClass,
  input  logic [NUM_EVT*OP_W-1:0]  evtOp,
  input  logic [NUM_EVT-1:0]       evtFromCache,
  input  logic [1:0]               vecTrapSel,
  input  logic                     staClr,
  input  logic [STA_W-1:0]         staClrMask,
  output logic [STA_W-1:0]         staRdData,
  output logic                     trapValid,
  output logic [1:0]               trapType,
  input  logic [DCHK_W-1:0]        genDataCheck,
  input  logic [TCHK_W-1:0]        genTagCheck,
  output logic [DCHK_W-1:0]        wrDataCheck,
  output logic [TCHK_W-1:0]        wrTagCheck
);
  ctrlStrb_t strb;
  logic      ceEn, ncEn, fastEn;

  errTrapCtrl #(.NUM_EVT(NUM_EVT)) uCtrl (
    .clk(clk), .rstN(rstN),
    .evtValid(evtValid), .evtClass(evtClass), .evtOp(evtOp),
    .evtFromCache(evtFromCache), .vecTrapSel(vecTrapSel),
    .ceEn(ceEn), .ncEn(ncEn), .fastEn(fastEn), .strb(strb)
  );

  errTrapDatapath #(.REG_W(REG_W), .DCHK_W(DCHK_W), .TCHK_W(TCHK_W)) uPath (
    .clk(clk), .rstN(rstN),
    .regWr(regWr), .regWrData(regWrData), .regRdData(regRdData),
    .staClr(staClr), .staClrMask(staClrMask), .staRdData(staRdData),
    .strb(strb), .trapValid(trapValid), .trapType(trapType),
    .genDataCheck(genDataCheck), .genTagCheck(genTagCheck),
    .wrDataCheck(wrDataCheck), .wrTagCheck(wrTagCheck),
    .ceEn(ceEn), .ncEn(ncEn), .fastEn(fastEn)
  );
endmodule

// File: tb/tb_eccTrapDispatch.sv
module tb_eccTrapDispatch;
  localparam int CLK_PERIOD = 10;
  localparam int NEVT = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [1:0]  evtValid = '0;
  logic [5:0]  evtClass = '0;
  logic [5:0]  evtOp = '0;
  logic [1:0]  evtFromCache = '0;
  logic [1:0]  vecTrapSel = '0;
  logic        staClr = 1'b0;
  logic [6:0]  staClrMask = '0;
  logic [6:0]  staRdData;
  logic        trapValid;
  logic [1:0]  trapType;
  logic [8:0]  genDataCheck = 9'h0C3;
  logic [3:0]  genTagCheck = 4'h5;
  logic [8:0]  wrDataCheck;
  logic [3:0]  wrTagCheck;

  int nChecks = 0;
  int nFail = 0;
  string curReq = "R1";

  logic [31:0] mEn = '0;
  logic [6:0]  mSta = '0;
  logic        mTrapV = 1'b0;
  logic [1:0]  mTrapT = '0;

  eccTrapDispatch dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regWrData(regWrData), .regRdData(regRdData),
    .evtValid(evtValid), .evtClass(evtClass), .evtOp(evtOp), .evtFromCache(evtFromCache),
    .vecTrapSel(vecTrapSel), .staClr(staClr), .staClrMask(staClrMask), .staRdData(staRdData),
    .trapValid(trapValid), .trapType(trapType), .genDataCheck(genDataCheck),
    .genTagCheck(genTagCheck), .wrDataCheck(wrDataCheck), .wrTagCheck(wrTagCheck)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", curReq, what, act, exp);
    end
  endtask

  task automatic modelEdge();
    logic [6:0] setV = '0;
    int best = 4;
    for (int i = 0; i < NEVT; i++) begin
      if (evtValid[i]) begin
        int c = int'(evtClass[3*i +: 3]);
        int o = int'(evtOp[3*i +: 3]);
        bit rd = (o == 0 || o == 1 || o == 2);
        if (evtFromCache[i] && rd && (c == 1 || c == 2)) begin
          setV[(c == 1) ? 0 : 1] = 1'b1;
          if (mEn[3] && best > 0) best = 0;
        end else if (c == 0 || c == 1) begin
          setV[2] = 1'b1;
          if (mEn[0] && best > 3) best = 3;
        end else if (c >= 2 && c <= 5) begin
          int k;
          setV[c + 1] = 1'b1;
          if (o == 1) k = 1;
          else if (o == 0 || o == 2) k = 2;
          else if (o == 6) k = (vecTrapSel == 2'd1) ? 1 : (vecTrapSel == 2'd2) ? 2 : 3;
          else k = 3;
          if (mEn[1] && k < best) best = k;
        end
      end
    end
    mSta   = (mSta & ~(staClr ? staClrMask : 7'd0)) | setV;
    if (regWr) mEn = regWrData & 32'h0007FFFB;
    mTrapV = (best < 4);
    mTrapT = (best < 4) ? 2'(best) : 2'd0;
  endtask

  task automatic compareAll();
    chk("trapValid", 32'(trapValid), 32'(mTrapV));
    if (mTrapV) chk("trapType", 32'(trapType), 32'(mTrapT));
    chk("status", 32'(staRdData), 32'(mSta));
    chk("ctrlReg", regRdData, mEn);
    chk("dataCheck", 32'(wrDataCheck), 32'(mEn[13] ? mEn[12:4] : genDataCheck));
    chk("tagCheck", 32'(wrTagCheck), 32'(mEn[18] ? mEn[17:14] : genTagCheck));
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    modelEdge();
    @(negedge clk);
    compareAll();
    evtValid = '0;
    regWr = 1'b0;
    staClr = 1'b0;
  endtask

  task automatic wrCtrl(input logic [31:0] v);
    regWr = 1'b1;
    regWrData = v;
    tick();
  endtask

  task automatic ev(input int p, input int cls, input int op, input bit cache);
    evtValid[p] = 1'b1;
    evtClass[3*p +: 3] = 3'(cls);
    evtOp[3*p +: 3] = 3'(op);
    evtFromCache[p] = cache;
  endtask

  task automatic clearAll();
    staClr = 1'b1;
    staClrMask = 7'h7F;
    tick();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    curReq = "R1";
    chk("reset trapValid", 32'(trapValid), 0);
    chk("reset status", 32'(staRdData), 0);
    chk("reset ctrlReg", regRdData, 0);
    rstN = 1'b1;
    tick();

    // R2: field layout and reserved bits
    curReq = "R2";
    wrCtrl(32'hFFFF_FFFF);
    chk("all-ones readback", regRdData, 32'h0007FFFB);
    tick();
    chk("hold without write", regRdData, 32'h0007FFFB);

    // R11: check bit override
    curReq = "R11";
    wrCtrl(32'h0 | (32'h1A5 << 4) | (32'h1 << 13));
    genDataCheck = 9'h03C; genTagCheck = 4'hA; tick();
    chk("forced data", 32'(wrDataCheck), 32'h1A5);
    chk("tag passthrough", 32'(wrTagCheck), 32'hA);
    wrCtrl((32'h6 << 14) | (32'h1 << 18));
    chk("forced tag", 32'(wrTagCheck), 32'h6);
    chk("data passthrough", 32'(wrDataCheck), 32'h03C);

    // R3: fast trap on cache read
    curReq = "R3";
    wrCtrl(32'h8);
    ev(0, 1, 0, 1); tick();
    chk("fast trap swcor load", 32'(trapType), 0);
    ev(0, 2, 1, 1); tick();
    ev(1, 2, 2, 1); tick();
    chk("fast status bits", 32'(staRdData), 32'h03);
    clearAll();

    // R4: cache errors on merge/writeback/copyout never fast
    curReq = "R4";
    wrCtrl(32'hB);
    ev(0, 2, 4, 1); tick();
    chk("wb uedata disrupt", 32'(trapType), 3);
    ev(0, 1, 3, 1); tick();
    ev(0, 2, 5, 1); tick();
    clearAll();

    // R5: uncorrectable routing by operation
    curReq = "R5";
    wrCtrl(32'h2);
    ev(0, 4, 1, 0); tick();
    chk("timeout ifetch instr", 32'(trapType), 1);
    ev(0, 5, 0, 0); tick();
    chk("buserr load data", 32'(trapType), 2);
    ev(1, 3, 5, 0); tick();
    ev(0, 2, 2, 0); tick();
    chk("status bits 3..6", 32'(staRdData), 32'h78);
    clearAll();

    // R6: interrupt-vector fetch resolution
    curReq = "R6";
    for (int s = 0; s < 4; s++) begin
      vecTrapSel = 2'(s);
      ev(0, 4, 6, 0); tick();
    end
    vecTrapSel = 2'd2;
    ev(1, 3, 6, 1); tick();
    chk("vec sel data", 32'(trapType), 2);
    clearAll();

    // R7: corrected errors
    curReq = "R7";
    wrCtrl(32'h1);
    ev(0, 0, 0, 0); tick();
    chk("hw corrected disrupt", 32'(trapType), 3);
    ev(0, 1, 3, 1); tick();
    ev(0, 1, 1, 1); tick();
    chk("swcor fast w/o fast enable no trap", 32'(trapValid), 0);
    clearAll();

    // R8: masked events are still logged
    curReq = "R8";
    wrCtrl(32'h0);
    ev(0, 5, 1, 0); ev(1, 0, 4, 0); tick();
    chk("masked no trap", 32'(trapValid), 0);
    chk("masked logged", 32'(staRdData), 32'h44);
    wrCtrl(32'h9);
    ev(0, 3, 0, 0); tick();
    chk("nc masked no trap", 32'(trapValid), 0);

    // R9: sticky status and set-wins
    curReq = "R9";
    tick();
    chk("sticky", 32'(staRdData), 32'h54);
    staClr = 1'b1; staClrMask = 7'h04; tick();
    chk("w1c one bit", 32'(staRdData), 32'h50);
    staClr = 1'b1; staClrMask = 7'h50; ev(0, 4, 0, 0); tick();
    chk("set wins over clear", 32'(staRdData), 32'h20);
    clearAll();

    // R10: precedence among simultaneous events
    curReq = "R10";
    wrCtrl(32'hB);
    ev(0, 4, 0, 0); ev(1, 1, 1, 1); tick();
    chk("fast beats data", 32'(trapType), 0);
    ev(0, 0, 0, 0); ev(1, 5, 1, 0); tick();
    chk("instr beats disrupt", 32'(trapType), 1);
    ev(0, 2, 2, 0); ev(1, 3, 4, 0); tick();
    chk("data beats disrupt", 32'(trapType), 2);
    tick();
    chk("single pulse", 32'(trapValid), 0);
    chk("all events logged", 32'(staRdData), 32'h7D);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule